// File: doc/BRIEF.md
# Iterative 32-bit Multiplier with Multiply-Accumulate

This block serves as the multiply unit of a processor execute stage. A 64-bit product of two 32-bit operands is built from a single 16x16 unsigned array multiplier. The array is used once for each pair of operand halves, and a 64-bit running sum collects the four partial products. Signed operands are handled in sign-magnitude form. The operand magnitudes are latched at start, and the final sum is negated when the operand signs differ. A parameter can add a register stage at the array output. This improves timing at the cost of one extra cycle of latency.

The same array also serves a multiply-accumulate operation. That operation takes the low halves of both operands, forms their 32-bit product in the cycle that start is accepted, and adds the product into a 40-bit accumulator. The accumulator can be cleared synchronously, and its value is always visible on an output. Multiply-accumulate requests are taken only while no iterative multiply is running, so the two uses of the array never collide.

Top module: `imul32_mac`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `result_o` and `acc_o` are all zero.
- R2: Operation code 2'b00 (unsigned multiply) sets `result_o` to the unsigned 64-bit product of `a_i` and `b_i`.
- R3: Operation code 2'b01 (signed multiply) sets `result_o` to the two's-complement 64-bit product of `a_i` and `b_i`, including the case where both operands are the most negative value.
- R4: For a multiply, `done_o` rises on the 4th rising edge after the edge that accepts `start_i` when `PIPE_MUL` is 0, and on the 5th such edge when `PIPE_MUL` is 1.
- R5: `busy_o` is high from the accepting edge up to the edge that raises `done_o`. `done_o` is high for exactly one cycle per multiply.
- R6: `result_o` changes only at an edge that also raises `done_o`. It holds its value until the next operation completes.
- R7: A `start_i` seen while `busy_o` is high has no effect on the running multiply, on `result_o`, or on `acc_o`.
- R8: Operation code 2'b10 (unsigned MAC) is accepted when `busy_o` is low. At the accepting edge it adds the zero-extended product `a_i[15:0]*b_i[15:0]` into `acc_o`, loads that product zero-extended into `result_o`, and raises `done_o` for one cycle. Back-to-back MACs are accepted on consecutive edges.
- R9: Operation code 2'b11 (signed MAC) works like R8, but treats the low halves as signed and sign-extends the 32-bit product.
- R10: The accumulator wraps modulo 2^40 in both directions.
- R11: `acc_clr_i` zeroes the accumulator at the next edge and takes priority over a MAC add at the same edge. A MAC accepted at that edge still updates `result_o` and `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation request, sampled when `busy_o` is low |
| op_i | input | 2 | Bit 1: MAC when set; bit 0: signed when set |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| acc_clr_i | input | 1 | Synchronous accumulator clear |
| busy_o | output | 1 | Iterative multiply in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2*DATA_W | Last completed product |
| acc_o | output | ACC_W | Accumulator value |

## Verification
Two instances, one without and one with the array register, are driven with the same stimulus. Small operands and all-ones operands show whether the partial products are shifted into the right place. The signed cases mix operand signs and include the most negative value, which separates a correct magnitude and negate path from a plain unsigned one. Starts issued into a running multiply, runs of MACs held on consecutive cycles, a signed MAC that goes below zero, a long unsigned run past 2^40, and a clear that coincides with a MAC cover the edge cases. A random mix of operations and gaps then checks that the latency and the one-cycle completion pulse stay correct for both instances.

// File: rtl/imul_pkg.sv
package imul_pkg;
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_MACU = 2'b10,
    OP_MACS = 2'b11
  } imul_op_e;

  localparam int unsigned NUM_STEPS = 4;
endpackage

// File: rtl/imul_core.sv
module imul_core #(
  parameter int unsigned HALF_W = 16,
  parameter bit          PIPE   = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [HALF_W-1:0]   x_i,
  input  logic [HALF_W-1:0]   y_i,
  input  logic                vld_i,
  input  logic [1:0]          sel_i,
  output logic [2*HALF_W-1:0] prod_comb_o,
  output logic [2*HALF_W-1:0] prod_o,
  output logic                vld_o,
  output logic [1:0]          sel_o
);
  localparam int unsigned PW = 2 * HALF_W;

  assign prod_comb_o = PW'(x_i) * PW'(y_i);

  generate
    if (PIPE) begin : g_pipe
      logic [PW-1:0] prod_q;
      logic          vld_q;
      logic [1:0]    sel_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prod_q <= '0;
          vld_q  <= 1'b0;
          sel_q  <= '0;
        end else begin
          prod_q <= prod_comb_o;
          vld_q  <= vld_i;
          sel_q  <= sel_i;
        end
      end
      assign prod_o = prod_q;
      assign vld_o  = vld_q;
      assign sel_o  = sel_q;

      // R4
      pipe_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o == $past(vld_i));
    end else begin : g_comb
      assign prod_o = prod_comb_o;
      assign vld_o  = vld_i;
      assign sel_o  = sel_i;
    end
  endgenerate

  // R2
  zero_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i == '0 || y_i == '0) |-> prod_comb_o == '0);
endmodule

// File: rtl/imul_iter.sv
module imul_iter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAT    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                signed_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [DATA_W-1:0]   pp_i,
  input  logic                pp_vld_i,
  input  logic [1:0]          pp_sel_i,
  output logic                busy_o,
  output logic [DATA_W/2-1:0] x_o,
  output logic [DATA_W/2-1:0] y_o,
  output logic                x_vld_o,
  output logic [1:0]          x_sel_o,
  output logic                fin_o,
  output logic [2*DATA_W-1:0] prod_o
);
  import imul_pkg::*;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned RES_W  = 2 * DATA_W;

  logic              busy_q, neg_q;
  logic [2:0]        iss_q;
  logic [DATA_W-1:0] am_q, bm_q;
  logic [RES_W-1:0]  sum_q, pp_sh, sum_d;
  logic [3:0]        lat_q;
  logic              go;

  assign go = start_i && !busy_q;

  always_comb begin
    case (pp_sel_i)
      2'd0:    pp_sh = RES_W'(pp_i);
      2'd3:    pp_sh = RES_W'(pp_i) << DATA_W;
      default: pp_sh = RES_W'(pp_i) << HALF_W;
    endcase
  end

  assign sum_d   = sum_q + pp_sh;
  assign prod_o  = neg_q ? -sum_d : sum_d;
  assign fin_o   = pp_vld_i && (pp_sel_i == 2'd3);
  // step order: lo*lo, lo*hi, hi*lo, hi*hi
  assign x_o     = iss_q[1] ? am_q[DATA_W-1:HALF_W] : am_q[HALF_W-1:0];
  assign y_o     = iss_q[0] ? bm_q[DATA_W-1:HALF_W] : bm_q[HALF_W-1:0];
  assign x_vld_o = busy_q && (iss_q < 3'(NUM_STEPS));
  assign x_sel_o = iss_q[1:0];
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      neg_q  <= 1'b0;
      iss_q  <= '0;
      am_q   <= '0;
      bm_q   <= '0;
      sum_q  <= '0;
      lat_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      iss_q  <= '0;
      am_q   <= (signed_i && a_i[DATA_W-1]) ? -a_i : a_i;
      bm_q   <= (signed_i && b_i[DATA_W-1]) ? -b_i : b_i;
      neg_q  <= signed_i && (a_i[DATA_W-1] ^ b_i[DATA_W-1]);
      sum_q  <= '0;
      lat_q  <= '0;
    end else if (busy_q) begin
      lat_q <= lat_q + 4'd1;
      if (x_vld_o) iss_q <= iss_q + 3'd1;
      if (pp_vld_i) sum_q <= sum_d;
      if (fin_o) busy_q <= 1'b0;
    end
  end

  // R4
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> lat_q == 4'(LAT - 1));
  // R5
  fin_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !busy_o && !fin_o);
  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fin_o) |=> busy_q);
endmodule

// File: rtl/imul_acc.sv
module imul_acc #(
  parameter int unsigned PP_W  = 32,
  parameter int unsigned ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             signed_i,
  input  logic [PP_W-1:0]  prod_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam int unsigned EXT_W = ACC_W - PP_W;

  logic [ACC_W-1:0] acc_q, prod_ext;

  assign prod_ext = {{EXT_W{signed_i & prod_i[PP_W-1]}}, prod_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q + prod_ext;
  end

  assign acc_o = acc_q;

  // R11
  acc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0);
  // R7
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(acc_o));
endmodule

// File: rtl/imul32_mac.sv
module imul32_mac #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ACC_W    = 40,
  parameter bit          PIPE_MUL = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          op_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic                acc_clr_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*DATA_W-1:0] result_o,
  output logic [ACC_W-1:0]    acc_o
);
  import imul_pkg::*;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned RES_W  = 2 * DATA_W;
  localparam int unsigned LAT    = NUM_STEPS + (PIPE_MUL ? 1 : 0);

  logic              mul_go, mac_go, sgn, mac_neg, fin;
  logic [HALF_W-1:0] a_lo, b_lo, mac_x, mac_y, it_x, it_y, core_x, core_y;
  logic              it_vld, pp_vld;
  logic [1:0]        it_sel, pp_sel;
  logic [DATA_W-1:0] pp_comb, pp, mac_p;
  logic [RES_W-1:0]  it_prod, mac_ext;
  logic              done_q;
  logic [RES_W-1:0]  res_q;

  assign sgn    = op_i[0];
  assign mul_go = start_i && !busy_o && !op_i[1];
  assign mac_go = start_i && !busy_o && op_i[1];

  assign a_lo    = a_i[HALF_W-1:0];
  assign b_lo    = b_i[HALF_W-1:0];
  assign mac_x   = (sgn && a_lo[HALF_W-1]) ? -a_lo : a_lo;
  assign mac_y   = (sgn && b_lo[HALF_W-1]) ? -b_lo : b_lo;
  assign mac_neg = sgn && (a_lo[HALF_W-1] ^ b_lo[HALF_W-1]);

  // array is free for MAC whenever no iteration is running
  assign core_x = busy_o ? it_x : mac_x;
  assign core_y = busy_o ? it_y : mac_y;

  imul_core #(.HALF_W(HALF_W), .PIPE(PIPE_MUL)) i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .x_i         (core_x),
    .y_i         (core_y),
    .vld_i       (it_vld),
    .sel_i       (it_sel),
    .prod_comb_o (pp_comb),
    .prod_o      (pp),
    .vld_o       (pp_vld),
    .sel_o       (pp_sel)
  );

  imul_iter #(.DATA_W(DATA_W), .LAT(LAT)) i_iter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (mul_go),
    .signed_i (sgn),
    .a_i      (a_i),
    .b_i      (b_i),
    .pp_i     (pp),
    .pp_vld_i (pp_vld),
    .pp_sel_i (pp_sel),
    .busy_o   (busy_o),
    .x_o      (it_x),
    .y_o      (it_y),
    .x_vld_o  (it_vld),
    .x_sel_o  (it_sel),
    .fin_o    (fin),
    .prod_o   (it_prod)
  );

  assign mac_p   = mac_neg ? -pp_comb : pp_comb;
  assign mac_ext = {{DATA_W{sgn & mac_p[DATA_W-1]}}, mac_p};

  imul_acc #(.PP_W(DATA_W), .ACC_W(ACC_W)) i_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (acc_clr_i),
    .en_i     (mac_go),
    .signed_i (sgn),
    .prod_i   (mac_p),
    .acc_o    (acc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= fin | mac_go;
      if (fin)         res_q <= it_prod;
      else if (mac_go) res_q <= mac_ext;
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;

  // R6
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);
endmodule

// File: tb/test_imul32_mac.sv
`timescale 1ns/1ps
module test_imul32_mac;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic clr = 1'b0;

  logic        busy [2];
  logic        done [2];
  logic [63:0] res  [2];
  logic [39:0] acc  [2];

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  imul32_mac #(.PIPE_MUL(1'b0)) i_imul32_mac (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .acc_clr_i(clr), .busy_o(busy[0]), .done_o(done[0]), .result_o(res[0]), .acc_o(acc[0]));

  imul32_mac #(.PIPE_MUL(1'b1)) i_imul32_mac_pipe (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .acc_clr_i(clr), .busy_o(busy[1]), .done_o(done[1]), .result_o(res[1]), .acc_o(acc[1]));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mul_ref(logic s, logic [31:0] x, logic [31:0] y);
    if (s) return 64'(longint'($signed(x)) * longint'($signed(y)));
    return 64'(x) * 64'(y);
  endfunction

  function automatic logic [63:0] mac_ref(logic s, logic [31:0] x, logic [31:0] y);
    if (s) return 64'(longint'($signed(x[15:0])) * longint'($signed(y[15:0])));
    return 64'(x[15:0]) * 64'(y[15:0]);
  endfunction

  // behavioural reference, one per instance (latency 4 and 5)
  logic        mb [2];
  int          mc [2];
  logic [63:0] mpend [2];
  logic [63:0] mres [2];
  logic        mdone [2];
  logic [39:0] macc [2];
  string       ptag [2];
  string       mtag [2];

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        mb[i] = 1'b0; mc[i] = 0; mpend[i] = '0; mres[i] = '0;
        mdone[i] = 1'b0; macc[i] = '0; ptag[i] = "R1"; mtag[i] = "R1";
      end else begin
        logic nd, mg;
        nd = 1'b0; mg = 1'b0;
        if (mb[i]) begin
          mc[i]++;
          if (mc[i] == 4 + i) begin
            mb[i] = 1'b0; nd = 1'b1; mres[i] = mpend[i]; mtag[i] = ptag[i];
          end
        end else if (start) begin
          if (!op[1]) begin
            mb[i] = 1'b1; mc[i] = 0; mpend[i] = mul_ref(op[0], a, b);
            ptag[i] = op[0] ? "R3 signed mul" : "R2 unsigned mul";
          end else begin
            nd = 1'b1; mg = 1'b1; mres[i] = mac_ref(op[0], a, b);
            mtag[i] = op[0] ? "R9 signed mac" : "R8 unsigned mac";
          end
        end
        if (clr) macc[i] = '0;
        else if (mg) macc[i] = macc[i] + mac_ref(op[0], a, b)[39:0];
        mdone[i] = nd;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        chk($sformatf("R4 done inst%0d", i), 64'(done[i]), 64'(mdone[i]));
        chk($sformatf("R5 busy inst%0d", i), 64'(busy[i]), 64'(mb[i]));
        chk($sformatf("%s result inst%0d", mtag[i], i), res[i], mres[i]);
        chk($sformatf("R10 acc inst%0d", i), 64'(acc[i]), 64'(macc[i]));
      end
    end
  end

  task automatic go(logic [1:0] o, logic [31:0] x, logic [31:0] y, logic c);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y; clr = c;
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle(3);
    for (int i = 0; i < 2; i++) begin
      // R1 reset state
      chk("R1 busy", 64'(busy[i]), 64'd0);
      chk("R1 done", 64'(done[i]), 64'd0);
      chk("R1 result", res[i], 64'd0);
      chk("R1 acc", 64'(acc[i]), 64'd0);
    end
    rst_n = 1'b1;
    idle(2);

    // R2 unsigned multiply
    go(2'b00, 32'd3, 32'd5, 1'b0); idle(6);
    for (int i = 0; i < 2; i++) chk("R6 result held", res[i], 64'd15);
    go(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0); idle(6);
    for (int i = 0; i < 2; i++) chk("R2 max", res[i], 64'hFFFF_FFFE_0000_0001);
    go(2'b00, 32'h1234_5678, 32'h0001_0000, 1'b0); idle(6);

    // R3 signed multiply
    go(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0); idle(6);
    go(2'b01, 32'h8000_0000, 32'h8000_0000, 1'b0); idle(6);
    for (int i = 0; i < 2; i++) chk("R3 min*min", res[i], 64'h4000_0000_0000_0000);
    go(2'b01, 32'h8000_0000, 32'd1, 1'b0); idle(6);
    go(2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFE, 1'b0); idle(6);
    go(2'b01, 32'd0, 32'hFFFF_FFFB, 1'b0); idle(6);

    // R7 starts during busy are ignored
    go(2'b00, 32'd6, 32'd7, 1'b0);
    go(2'b00, 32'd100, 32'd100, 1'b0);
    go(2'b10, 32'd9, 32'd9, 1'b0);
    idle(6);
    for (int i = 0; i < 2; i++) begin
      chk("R7 result", res[i], 64'd42);
      chk("R7 acc", 64'(acc[i]), 64'd0);
    end

    // R8 unsigned MAC, held start on consecutive edges
    @(negedge clk);
    start = 1'b1; op = 2'b10; a = 32'hABCD_FFFF; b = 32'h0000_FFFF;
    @(negedge clk); a = 32'd2; b = 32'd3;
    @(negedge clk); a = 32'h0000_8000; b = 32'h0000_8000;
    @(negedge clk); start = 1'b0;
    idle(2);

    // R9 / R10 signed MAC wraps below zero
    go(2'b00, 32'd0, 32'd0, 1'b1); idle(6);
    go(2'b11, 32'hFFFF, 32'd1, 1'b0);
    for (int i = 0; i < 2; i++) chk("R10 wrap down", 64'(acc[i]), 64'hFF_FFFF_FFFF);
    go(2'b11, 32'd1, 32'd1, 1'b0);
    for (int i = 0; i < 2; i++) chk("R10 wrap up", 64'(acc[i]), 64'd0);
    go(2'b11, 32'h8000, 32'h8000, 1'b0);
    go(2'b11, 32'h7FFF, 32'h8000, 1'b0);

    // R10 long unsigned run past 2^40
    go(2'b00, 32'd0, 32'd0, 1'b1); idle(6);
    @(negedge clk);
    start = 1'b1; op = 2'b10; a = 32'hFFFF; b = 32'hFFFF;
    repeat (300) @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2; i++)
      chk("R10 long run", 64'(acc[i]), 64'((41'd300 * 41'h0_FFFE_0001) & 41'hFF_FFFF_FFFF));

    // R11 clear wins over a coinciding MAC
    go(2'b10, 32'd5, 32'd5, 1'b1);
    for (int i = 0; i < 2; i++) begin
      chk("R11 acc cleared", 64'(acc[i]), 64'd0);
      chk("R11 result", res[i], 64'd25);
      chk("R11 done", 64'(done[i]), 64'd1);
    end

    // random mix
    for (int k = 0; k < 400; k++) begin
      go(2'($urandom_range(0, 3)), $urandom, $urandom, ($urandom_range(0, 15) == 0));
      idle($urandom_range(0, 6));
    end
    idle(10);
    summary();
  end
endmodule